// File: doc/BRIEF.md
# Condition-Bit Boolean Result Generator

This block converts condition register state into a 64-bit integer result in a single combinational step. It is meant to sit in an integer execute path next to the condition register file. It reads the full condition register together with a field selector, a bit index and an operation code, and it returns a result that the register writeback can store directly as a signed value.

There are two kinds of operation. The three-valued decode looks at one 4-bit field and turns its less-than and greater-than bits into -1, +1 or 0, which is the usual form of a compare outcome. The four single-bit operations look at one condition bit and return 1 or 0, either as is or inverted. The negative forms return all ones in place of 1. Writing the condition register and computing the compares that set it belong to other blocks.

Bit numbering counts from the most significant end. Field `f` occupies `cr_in[31-4f : 28-4f]`, so its less-than bit is `cr_in[31-4f]` and its greater-than bit is `cr_in[30-4f]`. Condition bit `i` is `cr_in[31-i]`.

Top module: `cbr_bool_gen`

## Requirements
- R1: With `op_sel` = 0 (three-valued), if the less-than bit `cr_in[31-4*fld_sel]` is 1, `result` is all ones.
- R2: With `op_sel` = 0, if the less-than bit is 0 and the greater-than bit `cr_in[30-4*fld_sel]` is 1, `result` is 1. If both bits are 0, `result` is 0.
- R3: With `op_sel` = 0, when both the less-than and greater-than bits are 1, the less-than bit wins and `result` is all ones.
- R4: With `op_sel` = 1 (direct), `result` is 1 when `cr_in[31-bit_idx]` is 1 and 0 when it is 0.
- R5: With `op_sel` = 2 (reversed), `result` is 0 when `cr_in[31-bit_idx]` is 1 and 1 when it is 0.
- R6: With `op_sel` = 3 (negative), `result` is all ones when `cr_in[31-bit_idx]` is 1 and 0 when it is 0.
- R7: With `op_sel` = 4 (negative reversed), `result` is 0 when `cr_in[31-bit_idx]` is 1 and all ones when it is 0.
- R8: For `op_sel` values 5, 6 and 7, `result` is 0 and `illegal_op` is 1. For `op_sel` values 0 to 4, `illegal_op` is 0.
- R9: In the three-valued operation `bit_idx` has no effect on `result`. In the single-bit operations `fld_sel` has no effect on `result`.
- R10: The block holds no state. `result` and `illegal_op` follow the present inputs without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cr_in | input | 32 | Condition register contents, field 0 in the top nibble |
| fld_sel | input | 3 | Field chosen for the three-valued operation |
| bit_idx | input | 5 | Condition bit chosen for the single-bit operations |
| op_sel | input | 3 | Operation code, 0 to 4 legal |
| result | output | 64 | Generated integer result |
| illegal_op | output | 1 | High when `op_sel` is not a legal code |

## Verification
The bench drives each field with both compare bits set. A design with the priority reversed would return +1 there instead of -1. It walks the condition bit index from 0 through 31 to catch a bit numbering taken from the wrong end, which would show up as mirrored results. It holds one selector fixed while it sweeps the unused one, so a design that mixes up the field path and the bit path changes its output when it should not. It also drives the three unused codes, where a design that falls through to a legal operation would return a nonzero value or leave the flag low.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

   // Operation codes. Any value from 5 to 7 is illegal.
   typedef enum logic [2:0] {
      OP_TRI  = 3'd0,
      OP_DIR  = 3'd1,
      OP_REV  = 3'd2,
      OP_NEG  = 3'd3,
      OP_NREV = 3'd4
   } cbr_op_e;

   localparam int unsigned OP_W = 3;

endpackage

// File: rtl/cbr_field_pick.sv
// Extracts the less-than and greater-than bits of one condition field.
// Field 0 sits at the most significant end of the register.
module cbr_field_pick #(
   parameter int unsigned CR_W    = 32,
   parameter int unsigned FIELD_W = 4,
   localparam int unsigned NUM_FIELDS = CR_W / FIELD_W,
   localparam int unsigned SEL_W      = $clog2(NUM_FIELDS)
) (
   input  logic [CR_W-1:0]  cr,
   input  logic [SEL_W-1:0] sel,
   output logic             lt_bit,
   output logic             gt_bit
);

   logic [NUM_FIELDS-1:0] lt_vec;
   logic [NUM_FIELDS-1:0] gt_vec;

   if (FIELD_W < 2) begin : g_bad_field
      $error("cbr_field_pick: FIELD_W must be at least 2");
   end
   if (CR_W % FIELD_W != 0) begin : g_bad_split
      $error("cbr_field_pick: CR_W must be a multiple of FIELD_W");
   end
   if (NUM_FIELDS != (1 << SEL_W)) begin : g_bad_count
      $error("cbr_field_pick: field count must be a power of two");
   end

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
      assign lt_vec[g] = cr[CR_W-1-FIELD_W*g];
      assign gt_vec[g] = cr[CR_W-2-FIELD_W*g];
   end

   assign lt_bit = lt_vec[sel];
   assign gt_bit = gt_vec[sel];

endmodule

// File: rtl/cbr_bit_pick.sv
// Selects one condition bit. Index 0 is the most significant bit.
module cbr_bit_pick #(
   parameter int unsigned CR_W = 32,
   localparam int unsigned IDX_W = $clog2(CR_W)
) (
   input  logic [CR_W-1:0]  cr,
   input  logic [IDX_W-1:0] idx,
   output logic             cond_bit
);

   logic [CR_W-1:0] msb_first;

   if (CR_W != (1 << IDX_W)) begin : g_bad_width
      $error("cbr_bit_pick: CR_W must be a power of two");
   end

   for (genvar g = 0; g < CR_W; g++) begin : g_flip
      assign msb_first[g] = cr[CR_W-1-g];
   end

   assign cond_bit = msb_first[idx];

endmodule

// File: rtl/cbr_value_shape.sv
// Turns the selected bits into the integer result for the chosen operation.
module cbr_value_shape
   import cbr_pkg::*;
#(
   parameter int unsigned RES_W = 64
) (
   input  logic [OP_W-1:0]  op,
   input  logic             lt_bit,
   input  logic             gt_bit,
   input  logic             cond_bit,
   output logic [RES_W-1:0] res,
   output logic             bad_op
);

   localparam logic [RES_W-1:0] V_ONES = '1;
   localparam logic [RES_W-1:0] V_ONE  = RES_W'(1);
   localparam logic [RES_W-1:0] V_ZERO = '0;

   if (RES_W < 2) begin : g_bad_res
      $error("cbr_value_shape: RES_W must be at least 2");
   end

   always_comb begin
      res    = V_ZERO;
      bad_op = 1'b0;
      case (op)
         OP_TRI:  res = lt_bit ? V_ONES : (gt_bit ? V_ONE : V_ZERO);
         OP_DIR:  res = cond_bit ? V_ONE  : V_ZERO;
         OP_REV:  res = cond_bit ? V_ZERO : V_ONE;
         OP_NEG:  res = cond_bit ? V_ONES : V_ZERO;
         OP_NREV: res = cond_bit ? V_ZERO : V_ONES;
         default: bad_op = 1'b1;
      endcase
   end

endmodule

// File: rtl/cbr_bool_gen.sv
module cbr_bool_gen
   import cbr_pkg::*;
#(
   parameter int unsigned CR_W    = 32,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned RES_W   = 64,
   localparam int unsigned SEL_W  = $clog2(CR_W / FIELD_W),
   localparam int unsigned IDX_W  = $clog2(CR_W)
) (
   input  logic [CR_W-1:0]  cr_in,
   input  logic [SEL_W-1:0] fld_sel,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic [OP_W-1:0]  op_sel,
   output logic [RES_W-1:0] result,
   output logic             illegal_op
);

   localparam logic [RES_W-1:0] ALL_ONES = '1;
   localparam logic [RES_W-1:0] JUST_ONE = RES_W'(1);

   logic lt_bit;
   logic gt_bit;
   logic cond_bit;

   cbr_field_pick #(.CR_W(CR_W), .FIELD_W(FIELD_W)) u_field (
      .cr     (cr_in),
      .sel    (fld_sel),
      .lt_bit (lt_bit),
      .gt_bit (gt_bit)
   );

   cbr_bit_pick #(.CR_W(CR_W)) u_bit (
      .cr       (cr_in),
      .idx      (bit_idx),
      .cond_bit (cond_bit)
   );

   cbr_value_shape #(.RES_W(RES_W)) u_shape (
      .op       (op_sel),
      .lt_bit   (lt_bit),
      .gt_bit   (gt_bit),
      .cond_bit (cond_bit),
      .res      (result),
      .bad_op   (illegal_op)
   );

   // The results that the selector paths produce for each operation.
   always_comb begin
      p_tri_lt_r1: assert (!(op_sel == OP_TRI && lt_bit) || result == ALL_ONES)
         else $error("R1 less-than not all ones");
      p_tri_gt_r2: assert (!(op_sel == OP_TRI && !lt_bit && gt_bit) || result == JUST_ONE)
         else $error("R2 greater-than not one");
      p_lt_wins_r3: assert (!(op_sel == OP_TRI && lt_bit && gt_bit) || result == ALL_ONES)
         else $error("R3 priority broken");
      p_direct_r4: assert (!(op_sel == OP_DIR) || result == (cond_bit ? JUST_ONE : '0))
         else $error("R4 direct mismatch");
      p_reverse_r5: assert (!(op_sel == OP_REV) || result == (cond_bit ? '0 : JUST_ONE))
         else $error("R5 reversed mismatch");
      p_negate_r6: assert (!(op_sel == OP_NEG) || result == (cond_bit ? ALL_ONES : '0))
         else $error("R6 negative mismatch");
      p_neg_rev_r7: assert (!(op_sel == OP_NREV) || result == (cond_bit ? '0 : ALL_ONES))
         else $error("R7 negative reversed mismatch");
      p_illegal_r8: assert (!illegal_op || result == '0)
         else $error("R8 illegal code gave nonzero result");
      p_legal_flag_r8: assert ((op_sel > OP_NREV) == illegal_op)
         else $error("R8 illegal flag wrong");
   end

endmodule

// File: tb/cbr_bool_gen_test.sv
module cbr_bool_gen_test;

   logic        clk = 1'b0;
   logic [31:0] cr_in = '0;
   logic [2:0]  fld_sel = '0;
   logic [4:0]  bit_idx = '0;
   logic [2:0]  op_sel = '0;
   logic [63:0] result;
   logic        illegal_op;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #5 clk = ~clk;  // 100 MHz

   cbr_bool_gen uut (
      .cr_in      (cr_in),
      .fld_sel    (fld_sel),
      .bit_idx    (bit_idx),
      .op_sel     (op_sel),
      .result     (result),
      .illegal_op (illegal_op)
   );

   function automatic logic [63:0] exp_res(input logic [31:0] c, input int f,
                                           input int b, input int op);
      logic lt, gt, cb;
      lt = c[31-4*f];
      gt = c[30-4*f];
      cb = c[31-b];
      case (op)
         0: return lt ? 64'hFFFF_FFFF_FFFF_FFFF : (gt ? 64'd1 : 64'd0);
         1: return cb ? 64'd1 : 64'd0;
         2: return cb ? 64'd0 : 64'd1;
         3: return cb ? 64'hFFFF_FFFF_FFFF_FFFF : 64'd0;
         4: return cb ? 64'd0 : 64'hFFFF_FFFF_FFFF_FFFF;
         default: return 64'd0;
      endcase
   endfunction

   function automatic string tag_of(input int op);
      case (op)
         0: return "R1/R2";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         4: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic apply(input logic [31:0] c, input int f, input int b, input int op);
      cr_in   = c;
      fld_sel = 3'(f);
      bit_idx = 5'(b);
      op_sel  = 3'(op);
      #2;
   endtask

   task automatic check(input string req, input logic [63:0] exp_r, input logic exp_ill);
      checks++;
      if (result !== exp_r || illegal_op !== exp_ill) begin
         fails++;
         $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                  req, result, illegal_op, exp_r, exp_ill);
      end
   endtask

   task automatic run_one(input string req, input logic [31:0] c, input int f,
                          input int b, input int op);
      apply(c, f, b, op);
      check(req, exp_res(c, f, b, op), op > 4);
   endtask

   initial begin : watchdog
      #1_000_000;
      if (!ended) begin
         ended = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] c;
      int unsigned seed_kick;
      @(negedge clk);

      // All-zero inputs give zero and a legal flag.
      apply(32'h0, 0, 0, 0);
      check("R2 zero state", 64'd0, 1'b0);

      // R1: less-than bit in each field.
      for (int f = 0; f < 8; f++) begin
         apply(32'h8000_0000 >> (4*f), f, 0, 0);
         check("R1", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      end
      // R2: greater-than only, then a field with only low bits set.
      for (int f = 0; f < 8; f++) begin
         apply(32'h4000_0000 >> (4*f), f, 0, 0);
         check("R2", 64'd1, 1'b0);
      end
      apply(32'h3333_3333, 5, 0, 0);
      check("R2 neither", 64'd0, 1'b0);
      // R3: both bits set in each field, neighbours cleared.
      for (int f = 0; f < 8; f++) begin
         apply(32'hC000_0000 >> (4*f), f, 0, 0);
         check("R3", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      end

      // R4 to R7: walk a single set bit and a single clear bit over every index.
      for (int op = 1; op <= 4; op++) begin
         for (int b = 0; b < 32; b++) begin
            run_one(tag_of(op), 32'h8000_0000 >> b, 0, b, op);
            run_one(tag_of(op), ~(32'h8000_0000 >> b), 0, b, op);
         end
      end

      // R8: illegal codes with busy inputs.
      for (int op = 5; op < 8; op++) begin
         apply(32'hFFFF_FFFF, 0, 0, op);
         check("R8", 64'd0, 1'b1);
      end

      // R9: sweeping the unused selector leaves the result unchanged.
      for (int b = 0; b < 32; b++) begin
         apply(32'h4000_0000, 0, b, 0);
         check("R9 bit_idx ignored", 64'd1, 1'b0);
      end
      for (int f = 0; f < 8; f++) begin
         apply(32'h0000_0001, f, 31, 3);
         check("R9 fld_sel ignored", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      end

      // R10: output follows inputs between clock edges.
      @(posedge clk);
      #1;
      apply(32'h0800_0000, 1, 0, 0);
      check("R10", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      apply(32'h0800_0000, 4, 4, 1);
      check("R10", 64'd1, 1'b0);

      // Constrained random with a fixed seed.
      seed_kick = $urandom(32'h5EED_0C0B);
      for (int n = 0; n < 3000; n++) begin
         int f, b, op;
         c  = $urandom;
         f  = int'($urandom % 8);
         b  = int'($urandom % 32);
         op = int'($urandom % 8);
         run_one(tag_of(op), c, f, b, op);
      end

      if (!ended) begin
         ended = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule